// File: doc/BRIEF.md
# Chipkill Line Controller with Rotating Parity

This block sits between a host port and nine narrow memory devices. Each 64-byte line lives whole in one device, next to an 8-bit check byte. Every stripe of eight data lines also has a parity line, and the parity line sits in a different device for each stripe. A read of a healthy line touches only the device that holds it. When the check byte disagrees with the data, the controller reads the other eight devices of the stripe and XORs their lines to rebuild the lost one.

A write runs a read-modify-write of both the data line and the parity line, so the parity always tracks what the devices actually store. The controller handles one request at a time. Each device port is a read strobe and a write strobe. A shared stripe index and shared write data go to all devices, and each device returns its line and check byte one cycle after its read strobe.

Top module: `chipkill_ctrl`

## Requirements
- R1: The check byte is the bitwise inverse of the XOR of the 64 data bytes, and it is written with every data line. A device that returns an all-zero line with a zero check byte fails the check and takes the rebuild path.
- R2: Host address bits [2:0] give the data position p, and bits [STRIPE_W+2:3] give the stripe s, which drives dev_addr_o. The parity device is s mod 9. Position p maps to device p when p is below the parity device, and to device p+1 otherwise.
- R3: A read whose check byte matches strobes exactly one device, the one that holds the line, and writes nothing. The response comes in the third cycle after acceptance, with that line's data and both flags low.
- R4: On a mismatch, the cycle after the first read strobes all eight other devices at once. The response comes in the fourth cycle after acceptance. It carries the XOR of those eight lines, with rsp_fixed_o high when that rebuilt line passes the check against the XOR of their check bytes.
- R5: If the rebuilt line fails its check, rsp_err_o is high and rsp_fixed_o is low, and no device is written during the request. The fixed and error flags are never high together.
- R6: A write performs four single-device accesses in consecutive cycles: read the target, read the parity device, write the target with the new line and its check byte, then write the parity device. The response comes in the fifth cycle after acceptance. A read and a write are never strobed in the same cycle.
- R7: The new parity line is old parity XOR old data XOR new data. The new parity check byte is old parity check XOR old data check XOR new data check.
- R8: req_ready_o drops in the cycle after a request is accepted and stays low until the response cycle. rsp_valid_o is a single-cycle pulse.
- R9: After reset, req_ready_o is high, rsp_valid_o is low, and no device strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle and accepting |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | STRIPE_W+3 | Line address {stripe, position} |
| req_wdata_i | input | 512 | Write line |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 512 | Read line (direct or rebuilt) |
| rsp_fixed_o | output | 1 | Line was rebuilt successfully |
| rsp_err_o | output | 1 | Rebuild failed, line uncorrectable |
| dev_rd_o | output | 9 | Per-device read strobe |
| dev_wr_o | output | 9 | Per-device write strobe |
| dev_addr_o | output | STRIPE_W | Stripe index shared by all devices |
| dev_wdata_o | output | 512 | Shared write line |
| dev_wck_o | output | 8 | Shared write check byte |
| dev_rdata_i | input | 9*512 | Read lines, device d at bits [d*512 +: 512] |
| dev_rck_i | input | 9*8 | Read check bytes, device d at bits [d*8 +: 8] |

## Verification
The assertions watch the strobe discipline on every cycle. A write strobe is always single, reads and writes never share a cycle, and a write strobe only follows device activity. Rebuild fans out to exactly eight devices, the address map never picks the parity device for data, the handshake goes busy after acceptance, and the flags stay mutually exclusive. The data itself can only be judged by the bench's scenarios: rebuild after a flipped bit or a dead device returning zeros, the uncorrectable case with two bad lines in one stripe, parity values after each read-modify-write, and parity rotating through stripe indices that wrap past nine.

// File: rtl/chk_pkg.sv
`timescale 1ns/1ps
package chk_pkg;
  localparam int unsigned CK_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_R_RD,
    ST_R_CHK,
    ST_R_REB,
    ST_W_RD_D,
    ST_W_RD_P,
    ST_W_WR_D,
    ST_W_WR_P
  } ctl_state_e;
endpackage

// File: rtl/chk_sum.sv
`timescale 1ns/1ps
module chk_sum #(
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  output logic [7:0]              sum_o
);
  logic [7:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(LINE_BYTES); i++) acc = acc ^ line_i[i*8 +: 8];
    sum_o = ~acc;  // inversion makes all-zero line+check fail
  end
endmodule

// File: rtl/chk_addr_map.sv
`timescale 1ns/1ps
module chk_addr_map #(
  parameter int unsigned NUM_DEV  = 9,
  parameter int unsigned STRIPE_W = 4,
  localparam int unsigned POS_W  = $clog2(NUM_DEV-1),
  localparam int unsigned DEV_W  = $clog2(NUM_DEV),
  localparam int unsigned ADDR_W = STRIPE_W + POS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [STRIPE_W-1:0] stripe_o,
  output logic [DEV_W-1:0]    pdev_o,
  output logic [DEV_W-1:0]    ddev_o
);
  logic [POS_W-1:0] pos;
  logic [DEV_W-1:0] pos_ext;
  int unsigned      pmod;

  always_comb begin
    stripe_o = addr_i[ADDR_W-1:POS_W];
    pos      = addr_i[POS_W-1:0];
    pos_ext  = DEV_W'(pos);
    pmod     = 32'(stripe_o) % NUM_DEV;
    pdev_o   = DEV_W'(pmod);
    ddev_o   = (pos_ext < pdev_o) ? pos_ext : pos_ext + DEV_W'(1);
  end

  AST_MAP_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ddev_o != pdev_o) && (32'(ddev_o) < NUM_DEV) && (32'(pdev_o) < NUM_DEV)); // R2
endmodule

// File: rtl/chk_rebuild.sv
`timescale 1ns/1ps
module chk_rebuild #(
  parameter int unsigned NUM_DEV = 9,
  parameter int unsigned LINE_W  = 512,
  localparam int unsigned DEV_W  = $clog2(NUM_DEV)
) (
  input  logic [NUM_DEV*LINE_W-1:0] rdata_i,
  input  logic [NUM_DEV*8-1:0]      rck_i,
  input  logic [DEV_W-1:0]          skip_i,
  output logic [LINE_W-1:0]         line_o,
  output logic [7:0]                ck_o
);
  always_comb begin
    line_o = '0;
    ck_o   = '0;
    for (int d = 0; d < int'(NUM_DEV); d++) begin
      if (DEV_W'(d) != skip_i) begin
        line_o = line_o ^ rdata_i[d*LINE_W +: LINE_W];
        ck_o   = ck_o ^ rck_i[d*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/chipkill_ctrl.sv
`timescale 1ns/1ps
module chipkill_ctrl
  import chk_pkg::*;
#(
  parameter int unsigned NUM_DEV    = 9,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned STRIPE_W   = 4,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned POS_W  = $clog2(NUM_DEV-1),
  localparam int unsigned DEV_W  = $clog2(NUM_DEV),
  localparam int unsigned ADDR_W = STRIPE_W + POS_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [LINE_W-1:0]           req_wdata_i,
  output logic                        rsp_valid_o,
  output logic [LINE_W-1:0]           rsp_rdata_o,
  output logic                        rsp_fixed_o,
  output logic                        rsp_err_o,
  output logic [NUM_DEV-1:0]          dev_rd_o,
  output logic [NUM_DEV-1:0]          dev_wr_o,
  output logic [STRIPE_W-1:0]         dev_addr_o,
  output logic [LINE_W-1:0]           dev_wdata_o,
  output logic [CK_W-1:0]             dev_wck_o,
  input  logic [NUM_DEV*LINE_W-1:0]   dev_rdata_i,
  input  logic [NUM_DEV*CK_W-1:0]     dev_rck_i
);
  ctl_state_e          state_q;
  logic [STRIPE_W-1:0] stripe_q;
  logic [DEV_W-1:0]    tgt_q, pdev_q;
  logic [LINE_W-1:0]   wdata_q, old_d_q, old_p_q, rdata_q;
  logic [CK_W-1:0]     old_ck_q, old_pck_q, new_ck_q;
  logic                rsp_valid_q, fixed_q, err_q;

  logic [STRIPE_W-1:0] map_stripe;
  logic [DEV_W-1:0]    map_pdev, map_ddev;
  logic [LINE_W-1:0]   tgt_line, pdev_line, reb_line, sum_in;
  logic [CK_W-1:0]     tgt_ck, pdev_ck, reb_ck, sum_out;
  logic [NUM_DEV-1:0]  tgt_oh, pdev_oh;
  logic                tgt_ok;

  chk_addr_map #(.NUM_DEV(NUM_DEV), .STRIPE_W(STRIPE_W)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (req_addr_i),
    .stripe_o (map_stripe),
    .pdev_o   (map_pdev),
    .ddev_o   (map_ddev)
  );

  chk_rebuild #(.NUM_DEV(NUM_DEV), .LINE_W(LINE_W)) u_reb (
    .rdata_i (dev_rdata_i),
    .rck_i   (dev_rck_i),
    .skip_i  (tgt_q),
    .line_o  (reb_line),
    .ck_o    (reb_ck)
  );

  chk_sum #(.LINE_BYTES(LINE_BYTES)) u_sum (
    .line_i (sum_in),
    .sum_o  (sum_out)
  );

  always_comb begin
    tgt_line  = dev_rdata_i[32'(tgt_q)*LINE_W +: LINE_W];
    tgt_ck    = dev_rck_i[32'(tgt_q)*CK_W +: CK_W];
    pdev_line = dev_rdata_i[32'(pdev_q)*LINE_W +: LINE_W];
    pdev_ck   = dev_rck_i[32'(pdev_q)*CK_W +: CK_W];
    tgt_oh    = NUM_DEV'(1) << tgt_q;
    pdev_oh   = NUM_DEV'(1) << pdev_q;
    // one checksum unit, shared by the states that need it
    unique case (state_q)
      ST_R_CHK: sum_in = tgt_line;
      ST_R_REB: sum_in = reb_line;
      default:  sum_in = wdata_q;
    endcase
    tgt_ok = (sum_out == tgt_ck);
  end

  always_comb begin
    dev_rd_o    = '0;
    dev_wr_o    = '0;
    dev_wdata_o = wdata_q;
    dev_wck_o   = sum_out;
    unique case (state_q)
      ST_R_RD:   dev_rd_o = tgt_oh;
      ST_R_CHK:  if (!tgt_ok) dev_rd_o = ~tgt_oh;
      ST_W_RD_D: dev_rd_o = tgt_oh;
      ST_W_RD_P: dev_rd_o = pdev_oh;
      ST_W_WR_D: dev_wr_o = tgt_oh;
      ST_W_WR_P: begin
        dev_wr_o    = pdev_oh;
        dev_wdata_o = old_p_q ^ old_d_q ^ wdata_q;
        dev_wck_o   = old_pck_q ^ old_ck_q ^ new_ck_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      stripe_q    <= '0;
      tgt_q       <= '0;
      pdev_q      <= '0;
      wdata_q     <= '0;
      old_d_q     <= '0;
      old_p_q     <= '0;
      old_ck_q    <= '0;
      old_pck_q   <= '0;
      new_ck_q    <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      fixed_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          stripe_q <= map_stripe;
          tgt_q    <= map_ddev;
          pdev_q   <= map_pdev;
          wdata_q  <= req_wdata_i;
          state_q  <= req_write_i ? ST_W_RD_D : ST_R_RD;
        end
        ST_R_RD: state_q <= ST_R_CHK;
        ST_R_CHK: begin
          if (tgt_ok) begin
            rsp_valid_q <= 1'b1;
            rdata_q     <= tgt_line;
            fixed_q     <= 1'b0;
            err_q       <= 1'b0;
            state_q     <= ST_IDLE;
          end else begin
            state_q <= ST_R_REB;
          end
        end
        ST_R_REB: begin
          rsp_valid_q <= 1'b1;
          rdata_q     <= reb_line;
          fixed_q     <= (sum_out == reb_ck);
          err_q       <= (sum_out != reb_ck);
          state_q     <= ST_IDLE;
        end
        ST_W_RD_D: state_q <= ST_W_RD_P;
        ST_W_RD_P: begin
          old_d_q  <= tgt_line;
          old_ck_q <= tgt_ck;
          state_q  <= ST_W_WR_D;
        end
        ST_W_WR_D: begin
          old_p_q   <= pdev_line;
          old_pck_q <= pdev_ck;
          new_ck_q  <= sum_out;
          state_q   <= ST_W_WR_P;
        end
        ST_W_WR_P: begin
          rsp_valid_q <= 1'b1;
          rdata_q     <= wdata_q;
          fixed_q     <= 1'b0;
          err_q       <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_fixed_o = fixed_q;
  assign rsp_err_o   = err_q;
  assign dev_addr_o  = stripe_q;

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
  AST_NO_RD_WR_MIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|dev_rd_o) && (|dev_wr_o))); // R6
  AST_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_wr_o) |-> ($countones(dev_wr_o) == 1)); // R6
  AST_WR_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_wr_o) |-> ($past(|dev_rd_o) || $past(|dev_wr_o))); // R6
  AST_REBUILD_FANOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(dev_rd_o) > 1) |-> ($countones(dev_rd_o) == NUM_DEV - 1)); // R4
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_fixed_o && rsp_err_o)); // R5
endmodule

// File: tb/sim_chipkill_ctrl.sv
`timescale 1ns/1ps
module sim_chipkill_ctrl;
  localparam int NUM_DEV = 9;
  localparam int LINE_BYTES = 64;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int STRIPE_W = 4;
  localparam int NSTR = 1 << STRIPE_W;
  localparam int ADDR_W = STRIPE_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic req_ready_o, rsp_valid_o, rsp_fixed_o, rsp_err_o;
  logic [LINE_W-1:0] rsp_rdata_o, dev_wdata_o;
  logic [NUM_DEV-1:0] dev_rd_o, dev_wr_o;
  logic [STRIPE_W-1:0] dev_addr_o;
  logic [7:0] dev_wck_o;
  logic [NUM_DEV*LINE_W-1:0] dev_rdata;
  logic [NUM_DEV*8-1:0] dev_rck;

  logic [LINE_W-1:0] mem_d [NUM_DEV][NSTR];
  logic [7:0]        mem_c [NUM_DEV][NSTR];
  logic [LINE_W-1:0] rd_line [NUM_DEV];
  logic [7:0]        rd_ck [NUM_DEV];
  bit                dead [NUM_DEV];
  logic [LINE_W-1:0] gold [NSTR][NUM_DEV-1];

  int n_chk = 0, n_fail = 0;
  bit last_fixed, last_err;

  always #4 clk = ~clk;

  chipkill_ctrl #(.NUM_DEV(NUM_DEV), .LINE_BYTES(LINE_BYTES), .STRIPE_W(STRIPE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .rsp_fixed_o(rsp_fixed_o), .rsp_err_o(rsp_err_o),
    .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o), .dev_addr_o(dev_addr_o),
    .dev_wdata_o(dev_wdata_o), .dev_wck_o(dev_wck_o),
    .dev_rdata_i(dev_rdata), .dev_rck_i(dev_rck)
  );

  // behavioural devices: one-cycle read latency, dead device returns zeros
  always @(posedge clk) begin
    for (int d = 0; d < NUM_DEV; d++) begin
      if (dev_rd_o[d]) begin
        rd_line[d] <= dead[d] ? '0 : mem_d[d][dev_addr_o];
        rd_ck[d]   <= dead[d] ? '0 : mem_c[d][dev_addr_o];
      end
      if (dev_wr_o[d]) begin
        mem_d[d][dev_addr_o] <= dev_wdata_o;
        mem_c[d][dev_addr_o] <= dev_wck_o;
      end
    end
  end

  always_comb begin
    for (int d = 0; d < NUM_DEV; d++) begin
      dev_rdata[d*LINE_W +: LINE_W] = rd_line[d];
      dev_rck[d*8 +: 8] = rd_ck[d];
    end
  end

  function automatic logic [7:0] ck_fn(input logic [LINE_W-1:0] l);
    logic [7:0] a = '0;
    for (int i = 0; i < LINE_BYTES; i++) a ^= l[i*8 +: 8];
    return ~a;
  endfunction

  function automatic int pdev_of(input int s);
    return s % NUM_DEV;
  endfunction

  function automatic int ddev_of(input int s, input int p);
    return (p < pdev_of(s)) ? p : p + 1;
  endfunction

  function automatic logic [NUM_DEV-1:0] oh(input int d);
    logic [NUM_DEV-1:0] v = '0;
    v[d] = 1'b1;
    return v;
  endfunction

  function automatic logic [LINE_W-1:0] pat(input int s, input int p, input int salt);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < LINE_W/32; i++)
      l[i*32 +: 32] = ((s+1) * 32'h9E3779B1) ^ (p * 32'h85EBCA6B) ^ (i * 32'h01010101) ^ salt;
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input int s, input int p, input logic [LINE_W-1:0] wd);
    int tgt, pd, n;
    logic [NUM_DEV-1:0] erd [6];
    logic [NUM_DEV-1:0] ewr [6];
    logic [LINE_W-1:0] od, op, reb;
    logic [7:0] oc, opc, rebc;
    bit clean, fix;
    string tag;
    pd = pdev_of(s);
    tgt = ddev_of(s, p);
    for (int k = 0; k < 6; k++) begin erd[k] = '0; ewr[k] = '0; end
    od  = dead[tgt] ? '0 : mem_d[tgt][s];
    oc  = dead[tgt] ? '0 : mem_c[tgt][s];
    op  = dead[pd] ? '0 : mem_d[pd][s];
    opc = dead[pd] ? '0 : mem_c[pd][s];
    reb = '0; rebc = '0;
    for (int d = 0; d < NUM_DEV; d++) if (d != tgt) begin
      reb  ^= dead[d] ? '0 : mem_d[d][s];
      rebc ^= dead[d] ? '0 : mem_c[d][s];
    end
    clean = (ck_fn(od) == oc);
    fix = (ck_fn(reb) == rebc);
    if (wr) begin
      n = 5; tag = "R6";
      erd[1] = oh(tgt); erd[2] = oh(pd); ewr[3] = oh(tgt); ewr[4] = oh(pd);
    end else if (clean) begin
      n = 3; tag = "R3"; erd[1] = oh(tgt);
    end else begin
      n = 4; tag = fix ? "R4" : "R5";
      erd[1] = oh(tgt); erd[2] = ~oh(tgt);
    end
    chk(req_ready_o === 1'b1, "R8 ready before request", LINE_W'(req_ready_o), 1);
    req_valid = 1'b1; req_write = wr;
    req_addr = ADDR_W'((s << 3) | p); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= n; k++) begin
      chk({dev_rd_o, dev_wr_o} === {erd[k], ewr[k]}, {tag, " device strobes"},
          LINE_W'({dev_rd_o, dev_wr_o}), LINE_W'({erd[k], ewr[k]}));
      chk(req_ready_o === (k == n), "R8 ready", LINE_W'(req_ready_o), LINE_W'(k == n));
      chk(rsp_valid_o === (k == n), "R8 rsp_valid", LINE_W'(rsp_valid_o), LINE_W'(k == n));
      if (k == 1) chk(dev_addr_o === STRIPE_W'(s), "R2 stripe index", LINE_W'(dev_addr_o), LINE_W'(s));
      if (k < n) @(negedge clk);
    end
    last_fixed = rsp_fixed_o;
    last_err = rsp_err_o;
    if (wr) begin
      chk(mem_d[tgt][s] === wd, "R6 data line", mem_d[tgt][s], wd);
      chk(mem_c[tgt][s] === ck_fn(wd), "R1 stored check", LINE_W'(mem_c[tgt][s]), LINE_W'(ck_fn(wd)));
      chk(mem_d[pd][s] === (op ^ od ^ wd), "R7 parity line", mem_d[pd][s], op ^ od ^ wd);
      chk(mem_c[pd][s] === (opc ^ oc ^ ck_fn(wd)), "R7 parity check",
          LINE_W'(mem_c[pd][s]), LINE_W'(opc ^ oc ^ ck_fn(wd)));
      gold[s][p] = wd;
    end else if (clean) begin
      chk(rsp_rdata_o === od, "R3 read data", rsp_rdata_o, od);
      chk({rsp_fixed_o, rsp_err_o} === 2'b00, "R3 flags", LINE_W'({rsp_fixed_o, rsp_err_o}), 0);
    end else begin
      chk(rsp_rdata_o === reb, "R4 rebuilt data", rsp_rdata_o, reb);
      chk({rsp_fixed_o, rsp_err_o} === {fix, !fix}, fix ? "R4 flags" : "R5 flags",
          LINE_W'({rsp_fixed_o, rsp_err_o}), LINE_W'({fix, !fix}));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] bad;
    int t, o;
    for (int d = 0; d < NUM_DEV; d++) begin
      dead[d] = 1'b0;
      rd_line[d] = '0;
      rd_ck[d] = '0;
      for (int s = 0; s < NSTR; s++) begin
        mem_d[d][s] = '0;
        mem_c[d][s] = (d == pdev_of(s)) ? 8'h00 : 8'hFF;
      end
    end
    for (int s = 0; s < NSTR; s++) for (int p = 0; p < NUM_DEV-1; p++) gold[s][p] = '0;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready_o === 1'b1, "R9 ready", LINE_W'(req_ready_o), 1);
    chk(rsp_valid_o === 1'b0, "R9 rsp_valid", LINE_W'(rsp_valid_o), 0);
    chk({dev_rd_o, dev_wr_o} === '0, "R9 strobes", LINE_W'({dev_rd_o, dev_wr_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R7 R1 R2: writes across all stripes, parity device wraps at stripe 9
    for (int s = 0; s < NSTR; s++) begin
      do_op(1'b1, s, 0, pat(s, 0, 32'h11));
      do_op(1'b1, s, s % 8, pat(s, s % 8, 32'h22));
      do_op(1'b1, s, 7, pat(s, 7, 32'h33));
    end
    do_op(1'b1, 4, 7, '0);  // all-zero data, overwrites earlier line

    // R3: clean reads, including a never-written line
    for (int s = 0; s < NSTR; s += 3) begin
      do_op(1'b0, s, 7, '0);
      chk(rsp_rdata_o === gold[s][7], "R3 golden", rsp_rdata_o, gold[s][7]);
    end
    do_op(1'b0, 2, 5, '0);

    // R4: one flipped bit in a stored line
    t = ddev_of(3, 2);
    mem_d[t][3][100] = ~mem_d[t][3][100];
    do_op(1'b0, 3, 2, '0);
    chk(last_fixed === 1'b1, "R4 fixed flag", LINE_W'(last_fixed), 1);
    chk(rsp_rdata_o === gold[3][2], "R4 golden", rsp_rdata_o, gold[3][2]);
    mem_d[t][3][100] = ~mem_d[t][3][100];

    // R1: device 4 dead, returns zero line with zero check
    dead[4] = 1'b1;
    do_op(1'b0, 5, 4, '0);
    chk(last_fixed === 1'b1, "R1 zero line detected", LINE_W'(last_fixed), 1);
    chk(rsp_rdata_o === gold[5][4], "R1 golden after rebuild", rsp_rdata_o, gold[5][4]);
    do_op(1'b0, 5, 0, '0);
    dead[4] = 1'b0;

    // R5: two damaged lines in one stripe
    t = ddev_of(6, 1);
    o = ddev_of(6, 2);
    mem_d[t][6][7] = ~mem_d[t][6][7];
    mem_d[o][6][300] = ~mem_d[o][6][300];
    bad = mem_d[t][6];
    do_op(1'b0, 6, 1, '0);
    chk(last_err === 1'b1, "R5 error flag", LINE_W'(last_err), 1);
    chk(mem_d[t][6] === bad, "R5 stored line unchanged", mem_d[t][6], bad);
    mem_d[t][6][7] = ~mem_d[t][6][7];
    mem_d[o][6][300] = ~mem_d[o][6][300];

    // R7: second write to the same line uses the updated parity
    do_op(1'b1, 9, 3, pat(9, 3, 32'h44));
    do_op(1'b0, 9, 3, '0);
    chk(rsp_rdata_o === gold[9][3], "R7 readback", rsp_rdata_o, gold[9][3]);

    summary();
    $finish;
  end
endmodule